// File: doc/BRIEF.md
# Modular Multiplier Coprocessor Host Interface

This block is the register front end of a modular multiplication coprocessor. It sits between a host processor bus and the arithmetic engine. The host bus has a chip select, a write enable, an address and a data bus. The block stores the three input operands, which are the two factors and the modulus. It holds the engine's result and runs the start, busy and completion handshake, ending with a level interrupt. Each operand is wider than a host word, so the host moves it as several words. Word index 0 holds the least significant word.

The three input operands are only ever written and the result is only ever read, so they share addresses. A store cycle to an operand region fills that input register. A load cycle to any operand region returns the matching word of the result. A fourth region holds the control register, which is written, and the status register, which is read.

A run starts when the host raises the run bit. The block then captures the operands it presents to the engine and holds them stable until the engine reports completion. In square mode the second factor drives both engine operand inputs.

Top module: `mmc_host_if`

## Requirements
- R1: After reset, the interrupt is 0, the engine start is 0, the read data is 0, and the status word reads 0.
- R2: The address is split into a region field and a word index. The region field is the top 2 bits: 0 = first factor, 1 = second factor, 2 = modulus, 3 = control/status. The word index is the low bits. A store writes host word i into bits [i*HOST_W +: HOST_W] of the selected operand.
- R3: A load cycle (chip select high, write enable low) returns its data on the read port from the next cycle. To regions 0 to 2 it returns result word i. To region 3 it returns status bit 0 = busy, bit 1 = interrupt, bit 2 = square mode, and the upper bits 0.
- R4: A control write with bit 0 = 1 starts a run only when the previous run bit was 0 and no run is active. A start raises the engine start output for exactly one cycle, beginning the cycle after the write. Rewriting 1 does not start another run.
- R5: Control bit 1 selects the mode. With 0, engine operand A is the first factor and B is the second factor. With 1, both A and B are the second factor and the square output is 1.
- R6: Status bit 0 reads 1 while a run is active, from the start pulse until the engine's done pulse. It also reads 1 in the cycle after an accepted operand store. Otherwise it reads 0.
- R7: The interrupt rises the cycle after the engine's done pulse. It stays high until a load of the highest word index of the result, and reads of other words or of status leave it high.
- R8: Operand stores while a run is active are ignored.
- R9: Bus cycles with chip select low have no effect.
- R10: The engine operand and modulus outputs stay unchanged for the whole of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Chip select of this coprocessor |
| bus_we | input | 1 | 1 = store cycle, 0 = load cycle |
| bus_addr | input | ADDR_W | Region field and word index |
| bus_wdata | input | HOST_W | Store data |
| bus_rdata | output | HOST_W | Load data, registered |
| irq | output | 1 | Completion interrupt, level |
| eng_start | output | 1 | One-cycle run start to the engine |
| eng_square | output | 1 | Square mode select |
| eng_op_a | output | OP_W | Engine operand A |
| eng_op_b | output | OP_W | Engine operand B |
| eng_mod | output | OP_W | Modulus |
| eng_done | input | 1 | Engine completion pulse |
| eng_result | input | OP_W | Engine result, valid with done |

## Verification
The bound checker checks the following on every cycle:
- the start pulse lasts one cycle and never occurs during a run;
- the operand outputs stay stable through a run, and the two operands are equal in square mode;
- the interrupt rises after done, holds until the clearing read, and drops after it.

Some behaviours only the bench's scenarios can show:
- word placement across the operand and result;
- the shared-address split between stores and loads;
- the status encoding and its busy flag after stores;
- stores being ignored when they arrive mid-run or with chip select low;
- the total number of runs started.

These scenarios use an engine stub that returns (A + B) XOR M after a fixed latency.

// File: rtl/mmc_pkg.sv
package mmc_pkg;
  typedef enum logic [1:0] {
    RGN_X   = 2'd0,
    RGN_Y   = 2'd1,
    RGN_M   = 2'd2,
    RGN_CSR = 2'd3
  } region_e;

  localparam int CTL_RUN_BIT  = 0;
  localparam int CTL_SQR_BIT  = 1;
  localparam int STS_BUSY_BIT = 0;
  localparam int STS_IRQ_BIT  = 1;
  localparam int STS_MODE_BIT = 2;
  localparam int N_OPERANDS   = 3;
endpackage

// File: rtl/mmc_operand_bank.sv
module mmc_operand_bank #(
  parameter int HOST_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [HOST_W-1:0]         wr_data,
  output logic [HOST_W*WORDS-1:0]   value
);
  logic [HOST_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign value[w*HOST_W +: HOST_W] = mem[w];
  end
endmodule

// File: rtl/mmc_ctrl.sv
module mmc_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic ctl_wr,
  input  logic ctl_run,
  input  logic ctl_sqr,
  input  logic opnd_wr_req,
  input  logic eng_done,
  input  logic irq_clear_rd,
  output logic start_cond,
  output logic opnd_wr_ok,
  output logic start_q,
  output logic square_q,
  output logic active_q,
  output logic irq_q,
  output logic busy
);
  logic run_q;
  logic wr_pend_q;

  assign start_cond = ctl_wr & ctl_run & ~run_q & ~active_q;
  assign opnd_wr_ok = opnd_wr_req & ~active_q;
  assign busy       = active_q | wr_pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      square_q  <= 1'b0;
      start_q   <= 1'b0;
      active_q  <= 1'b0;
      irq_q     <= 1'b0;
      wr_pend_q <= 1'b0;
    end else begin
      if (ctl_wr) run_q <= ctl_run;
      if (ctl_wr && !active_q) square_q <= ctl_sqr;
      start_q   <= start_cond;
      wr_pend_q <= opnd_wr_ok;
      if (start_cond) active_q <= 1'b1;
      else if (eng_done) active_q <= 1'b0;
      if (eng_done && active_q) irq_q <= 1'b1;
      else if (irq_clear_rd) irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mmc_result_rd.sv
module mmc_result_rd #(
  parameter int HOST_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W = $clog2(WORDS),
  localparam int OP_W  = HOST_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [OP_W-1:0]   result,
  input  logic              rd_en,
  input  logic              rd_csr,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [HOST_W-1:0] status_word,
  output logic [HOST_W-1:0] rdata_q
);
  logic [OP_W-1:0] s_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q     <= '0;
      rdata_q <= '0;
    end else begin
      if (capture) s_q <= result;
      if (rd_en) rdata_q <= rd_csr ? status_word : s_q[rd_idx*HOST_W +: HOST_W];
    end
  end
endmodule

// File: rtl/mmc_host_if.sv
module mmc_host_if #(
  parameter int HOST_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int ADDR_W = IDX_W + 2,
  localparam int OP_W   = HOST_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HOST_W-1:0] bus_wdata,
  output logic [HOST_W-1:0] bus_rdata,
  output logic              irq,
  output logic              eng_start,
  output logic              eng_square,
  output logic [OP_W-1:0]   eng_op_a,
  output logic [OP_W-1:0]   eng_op_b,
  output logic [OP_W-1:0]   eng_mod,
  input  logic              eng_done,
  input  logic [OP_W-1:0]   eng_result
);
  import mmc_pkg::*;

  region_e          region;
  logic [IDX_W-1:0] idx;
  logic             wr_cyc, rd_cyc, is_csr;
  logic             start_cond, opnd_wr_ok, active_w, busy_w, square_w, irq_w;
  logic [OP_W-1:0]  opnd [N_OPERANDS];
  logic [OP_W-1:0]  op_a_q, op_b_q, mod_q;
  logic [HOST_W-1:0] status_word;

  assign region = region_e'(bus_addr[ADDR_W-1 -: 2]);
  assign idx    = bus_addr[IDX_W-1:0];
  assign wr_cyc = bus_cs & bus_we;
  assign rd_cyc = bus_cs & ~bus_we;
  assign is_csr = (region == RGN_CSR);

  for (genvar g = 0; g < N_OPERANDS; g++) begin : g_bank
    mmc_operand_bank #(.HOST_W(HOST_W), .WORDS(WORDS)) bank_i (
      .clk     (clk),
      .wr_en   (opnd_wr_ok && (region == region_e'(g))),
      .wr_idx  (idx),
      .wr_data (bus_wdata),
      .value   (opnd[g])
    );
  end

  mmc_ctrl ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .ctl_wr       (wr_cyc & is_csr),
    .ctl_run      (bus_wdata[CTL_RUN_BIT]),
    .ctl_sqr      (bus_wdata[CTL_SQR_BIT]),
    .opnd_wr_req  (wr_cyc & ~is_csr),
    .eng_done     (eng_done),
    .irq_clear_rd (rd_cyc && !is_csr && (idx == IDX_W'(WORDS-1))),
    .start_cond   (start_cond),
    .opnd_wr_ok   (opnd_wr_ok),
    .start_q      (eng_start),
    .square_q     (square_w),
    .active_q     (active_w),
    .irq_q        (irq_w),
    .busy         (busy_w)
  );

  always_comb begin
    status_word               = '0;
    status_word[STS_BUSY_BIT] = busy_w;
    status_word[STS_IRQ_BIT]  = irq_w;
    status_word[STS_MODE_BIT] = square_w;
  end

  mmc_result_rd #(.HOST_W(HOST_W), .WORDS(WORDS)) rd_i (
    .clk         (clk),
    .rst         (rst),
    .capture     (eng_done & active_w),
    .result      (eng_result),
    .rd_en       (rd_cyc),
    .rd_csr      (is_csr),
    .rd_idx      (idx),
    .status_word (status_word),
    .rdata_q     (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_a_q <= '0;
      op_b_q <= '0;
      mod_q  <= '0;
    end else if (start_cond) begin
      op_a_q <= bus_wdata[CTL_SQR_BIT] ? opnd[RGN_Y] : opnd[RGN_X];
      op_b_q <= opnd[RGN_Y];
      mod_q  <= opnd[RGN_M];
    end
  end

  assign eng_op_a   = op_a_q;
  assign eng_op_b   = op_b_q;
  assign eng_mod    = mod_q;
  assign eng_square = square_w;
  assign irq        = irq_w;
endmodule

// File: rtl/mmc_host_if_chk.sv
module mmc_host_if_chk #(
  parameter int HOST_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int ADDR_W = IDX_W + 2,
  localparam int OP_W   = HOST_W * WORDS
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_cs,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              eng_start,
  input logic              eng_done,
  input logic              eng_square,
  input logic              irq,
  input logic              run_active,
  input logic [OP_W-1:0]   eng_op_a,
  input logic [OP_W-1:0]   eng_op_b,
  input logic [OP_W-1:0]   eng_mod
);
  logic clr_rd;
  assign clr_rd = bus_cs && !bus_we && (bus_addr[ADDR_W-1 -: 2] != 2'd3)
                  && (bus_addr[IDX_W-1:0] == IDX_W'(WORDS-1));

  p_start_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);
  p_no_start_in_run_r4: assert property (@(posedge clk) disable iff (rst)
    (run_active && !eng_done) |=> !eng_start);
  p_start_marks_busy_r6: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> run_active);
  p_square_same_ops_r5: assert property (@(posedge clk) disable iff (rst)
    (run_active && eng_square) |-> (eng_op_a == eng_op_b));
  p_ops_stable_r10: assert property (@(posedge clk) disable iff (rst)
    run_active |=> ($stable(eng_op_a) && $stable(eng_op_b) && $stable(eng_mod)));
  p_irq_set_r7: assert property (@(posedge clk) disable iff (rst)
    (eng_done && run_active) |=> irq);
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_rd) |=> irq);
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_rd && !(eng_done && run_active)) |=> !irq);
endmodule

bind mmc_host_if mmc_host_if_chk #(.HOST_W(HOST_W), .WORDS(WORDS)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bus_cs     (bus_cs),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .eng_start  (eng_start),
  .eng_done   (eng_done),
  .eng_square (eng_square),
  .irq        (irq),
  .run_active (active_w),
  .eng_op_a   (eng_op_a),
  .eng_op_b   (eng_op_b),
  .eng_mod    (eng_mod)
);

// File: tb/mmc_host_if_tb_top.sv
`timescale 1ns/1ps
module mmc_host_if_tb_top;
  localparam int HOST_W = 32;
  localparam int WORDS  = 4;
  localparam int IDX_W  = $clog2(WORDS);
  localparam int ADDR_W = IDX_W + 2;
  localparam int OP_W   = HOST_W * WORDS;
  localparam int LAT    = 20;
  localparam logic [ADDR_W-1:0] CSR = {2'b11, {IDX_W{1'b0}}};

  logic clk = 0, rst = 1;
  logic bus_cs = 0, bus_we = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [HOST_W-1:0] bus_wdata = '0;
  logic [HOST_W-1:0] bus_rdata;
  logic irq, eng_start, eng_square, eng_done;
  logic [OP_W-1:0] eng_op_a, eng_op_b, eng_mod, eng_result;

  always #2.5 clk = ~clk;

  mmc_host_if #(.HOST_W(HOST_W), .WORDS(WORDS)) dut_i (.*);

  // engine stub: (A + B) ^ M after LAT cycles
  int stub_cnt = 0;
  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (rst) begin
      stub_cnt <= 0; eng_result <= '0;
    end else if (eng_start) begin
      stub_cnt <= LAT;
      eng_result <= (eng_op_a + eng_op_b) ^ eng_mod;
    end else if (stub_cnt > 0) begin
      stub_cnt <= stub_cnt - 1;
      if (stub_cnt == 1) eng_done <= 1'b1;
    end
  end

  int n_checks = 0, n_errors = 0, n_starts = 0;
  bit done_flag = 0;
  logic [HOST_W-1:0] exp_q [$];
  string tag_q [$];
  logic rd_pend = 0;

  task automatic check(logic [OP_W-1:0] act, logic [OP_W-1:0] exp, string req);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare load data the cycle after each load
  always @(posedge clk) rd_pend <= bus_cs & ~bus_we;
  always @(negedge clk) begin
    if (eng_start) n_starts++;
    if (rd_pend && exp_q.size() > 0) check(OP_W'(bus_rdata), OP_W'(exp_q.pop_front()), tag_q.pop_front());
  end

  logic [OP_W-1:0] xv, yv, mv;

  task automatic bus_write(logic [ADDR_W-1:0] a, logic [HOST_W-1:0] d);
    @(negedge clk); bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_cs = 0; bus_we = 0;
  endtask

  task automatic bus_read(logic [ADDR_W-1:0] a, logic [HOST_W-1:0] e, string req);
    @(negedge clk); exp_q.push_back(e); tag_q.push_back(req);
    bus_cs = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_cs = 0;
  endtask

  task automatic write_then_status(logic [ADDR_W-1:0] a, logic [HOST_W-1:0] d);
    @(negedge clk); bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0; bus_addr = CSR;
    exp_q.push_back(32'h1); tag_q.push_back("R6 busy after store");
    @(negedge clk); bus_cs = 0;
  endtask

  task automatic load_operand(logic [1:0] rgn, logic [OP_W-1:0] v);
    for (int i = 0; i < WORDS; i++) bus_write({rgn, IDX_W'(i)}, v[i*HOST_W +: HOST_W]);
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 1000 && !irq; i++) @(negedge clk);
    check(OP_W'(irq), 1, "R7 irq after done");
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      xv[i*HOST_W +: HOST_W] = 32'hA000_0000 + i;
      yv[i*HOST_W +: HOST_W] = 32'hB000_0010 + i;
      mv[i*HOST_W +: HOST_W] = 32'hC000_0100 + i;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(OP_W'(irq), 0, "R1 irq");
    check(OP_W'(eng_start), 0, "R1 start");
    check(OP_W'(bus_rdata), 0, "R1 rdata");
    bus_read(CSR, 32'h0, "R1 status");

    // run 1: multiply
    for (int i = 0; i < WORDS - 1; i++) bus_write({2'd0, IDX_W'(i)}, xv[i*HOST_W +: HOST_W]);
    write_then_status({2'd0, IDX_W'(WORDS-1)}, xv[(WORDS-1)*HOST_W +: HOST_W]);
    bus_read(CSR, 32'h0, "R6 idle after store");
    load_operand(2'd1, yv);
    load_operand(2'd2, mv);
    bus_write(CSR, 32'h1);
    check(OP_W'(eng_start), 1, "R4 start pulse");
    check(eng_op_a, xv, "R2/R5 op_a = X");
    check(eng_op_b, yv, "R2/R5 op_b = Y");
    check(eng_mod, mv, "R2 modulus");
    @(negedge clk);
    check(OP_W'(eng_start), 0, "R4 pulse length");
    bus_write({2'd0, IDX_W'(0)}, 32'hDEAD_BEEF);   // R8: ignored mid-run
    bus_read(CSR, 32'h1, "R6 busy in run");
    bus_write(CSR, 32'h1);                          // R4: no new start
    wait_irq();
    for (int i = 0; i < WORDS - 1; i++) begin
      bus_read({2'd0, IDX_W'(i)}, ((xv + yv) ^ mv) >> (i*HOST_W), "R3 result word");
      check(OP_W'(irq), 1, "R7 irq held");
    end
    bus_read(CSR, 32'h2, "R3 status irq");
    bus_read({2'd2, IDX_W'(WORDS-1)}, ((xv + yv) ^ mv) >> ((WORDS-1)*HOST_W), "R3 top word");
    check(OP_W'(irq), 0, "R7 irq cleared");
    bus_write(CSR, 32'h1);
    check(OP_W'(eng_start), 0, "R4 run bit already set");

    // run 2: square
    bus_write(CSR, 32'h0);
    bus_write(CSR, 32'h3);
    check(OP_W'(eng_square), 1, "R5 square flag");
    check(eng_op_a, yv, "R5 square op_a = Y");
    check(eng_op_b, yv, "R5 square op_b = Y");
    wait_irq();
    bus_read(CSR, 32'h6, "R3 status square irq");
    for (int i = 0; i < WORDS; i++)
      bus_read({2'd1, IDX_W'(i)}, ((yv + yv) ^ mv) >> (i*HOST_W), "R5 square result");

    // run 3: chip-select-low store must not land
    @(negedge clk); bus_cs = 0; bus_we = 1; bus_addr = {2'd1, IDX_W'(0)}; bus_wdata = 32'h1234_5678;
    @(negedge clk); bus_we = 0;
    bus_write(CSR, 32'h0);
    bus_write(CSR, 32'h1);
    check(eng_op_a, xv, "R8 mid-run store ignored");
    check(eng_op_b, yv, "R9 cs-low store ignored");
    check(OP_W'(eng_square), 0, "R5 multiply flag");
    wait_irq();
    bus_read({2'd0, IDX_W'(WORDS-1)}, ((xv + yv) ^ mv) >> ((WORDS-1)*HOST_W), "R3 top word run3");
    check(OP_W'(irq), 0, "R7 irq cleared run3");
    repeat (2) @(negedge clk);
    check(OP_W'(n_starts), 3, "R4 start count");
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule